// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block works out where the fetch stage of a small processor goes next, for a program memory that is addressed by word. Each cycle the decoder presents the current program counter and a class code. The class says whether the instruction is an ordinary one, a relative jump, a jump through the 16-bit Z pointer, a jump to an absolute address, a conditional branch on one status bit, or a skip. The decoder also supplies the operands that class needs. The unit returns the following program counter, how many cycles the instruction occupies, and a flush flag. The flush flag tells fetch to throw away the word it has already prefetched.

Results are registered, so they appear one clock after a valid request. Branch and jump offsets are signed two's-complement values, and they are sign-extended to the counter width before the add. All counter arithmetic wraps modulo 2^PC_W. A skip moves past the next instruction. How far it moves, and how long it takes, depends on whether that instruction occupies one word or two. Return addresses, interrupt entry and instruction decoding belong to other blocks.

Top module: `branch_nextpc_unit`

## Requirements
- R1: While rst_n is low, out_valid, next_pc, cycles and flush are all 0.
- R2: out_valid equals the in_valid of the previous clock. When in_valid is low, next_pc, cycles and flush keep their previous values.
- R3: Class 0 (sequential) gives next_pc = pc + 1 and cycles = 1.
- R4: Class 1 (relative jump) gives next_pc = pc + sign-extended 12-bit rel_off + 1 and cycles = 2.
- R5: Class 2 (indirect jump) gives next_pc = zptr and cycles = 2.
- R6: Class 3 (direct jump) gives next_pc = jmp_target and cycles = 3.
- R7: Class 4 (conditional branch) reads the status bit picked by flag_sel. The branch is taken when that bit equals flag_on_set. A taken branch gives pc + sign-extended 7-bit br_off + 1 and cycles = 2. A branch that is not taken gives pc + 1 and cycles = 1.
- R8: Status bit layout: bit 0 carry, bit 2 negative, bit 3 overflow, bit 4 signed (kept equal to negative XOR overflow by its producer). Same-or-higher is a branch on bit 0 clear and lower is a branch on bit 0 set. Signed greater-or-equal is a branch on bit 4 clear and signed less-than is a branch on bit 4 set.
- R9: Class 5 (skip) gives pc + 1 and cycles 1 when skip_cond is 0. When skip_cond is 1 it gives pc + 2 and cycles 2 if next_two_word is 0, and pc + 3 and cycles 3 if next_two_word is 1.
- R10: flush is 1 exactly when next_pc differs from pc + 1. This includes a relative jump with offset 0, which does not flush.
- R11: All next-PC sums wrap modulo 2^PC_W.
- R12: The unused class codes 6 and 7 behave as class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is present this cycle |
| cls | input | 3 | Instruction class code |
| pc | input | PC_W | Current program counter |
| rel_off | input | REL_W | Signed relative-jump offset |
| br_off | input | BR_W | Signed conditional-branch offset |
| jmp_target | input | PC_W | Absolute jump address |
| zptr | input | Z_W | Z pointer for the indirect jump |
| sreg | input | FLAG_W | Status flags |
| flag_sel | input | clog2(FLAG_W) | Index of the status bit tested by a branch |
| flag_on_set | input | 1 | 1: branch when the bit is set; 0: branch when it is clear |
| skip_cond | input | 1 | The skip condition holds |
| next_two_word | input | 1 | The instruction after this one occupies two words |
| out_valid | output | 1 | Result valid |
| next_pc | output | PC_W | Following program counter |
| cycles | output | 2 | Cycle count of the instruction |
| flush | output | 1 | The prefetched word must be discarded |

## Verification
An error in the output register, or in the choice of class, appears at next_pc and cycles on the very next clock after the request. It is always compared against a model that keeps its own copy of the previous request. An error in the hold path shows up on the first idle cycle, when the outputs change with no request behind them. An error in sign extension or wrap only appears for offsets at their extremes and for counters near the top of the range, so the directed cases aim at those points.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;
   localparam logic [2:0] CLS_SEQ    = 3'd0;
   localparam logic [2:0] CLS_RJMP   = 3'd1;
   localparam logic [2:0] CLS_IJMP   = 3'd2;
   localparam logic [2:0] CLS_JMP    = 3'd3;
   localparam logic [2:0] CLS_BRANCH = 3'd4;
   localparam logic [2:0] CLS_SKIP   = 3'd5;

   typedef logic [1:0] cyc_t;
   localparam cyc_t CYC_ONE   = 2'd1;
   localparam cyc_t CYC_TWO   = 2'd2;
   localparam cyc_t CYC_THREE = 2'd3;
endpackage

// File: rtl/bnpc_offset_add.sv
module bnpc_offset_add #(
   parameter int PC_W  = 16,
   parameter int OFF_W = 12
) (
   input  logic [PC_W-1:0]  base,
   input  logic [OFF_W-1:0] off,
   output logic [PC_W-1:0]  sum
);
   localparam logic [PC_W-1:0] ONE = 1;

   logic [PC_W-1:0] ext;

   generate
      if (OFF_W >= PC_W) begin : g_trunc
         assign ext = off[PC_W-1:0];
      end else begin : g_sext
         assign ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
      end
   endgenerate

   assign sum = base + ext + ONE;
endmodule

// File: rtl/bnpc_target_sel.sv
module bnpc_target_sel
   import bnpc_pkg::*;
#(
   parameter int PC_W = 16,
   parameter int Z_W  = 16
) (
   input  logic [2:0]      cls,
   input  logic [PC_W-1:0] pc,
   input  logic [PC_W-1:0] rel_sum,
   input  logic [PC_W-1:0] br_sum,
   input  logic [PC_W-1:0] jmp_target,
   input  logic [Z_W-1:0]  zptr,
   input  logic            flag_hit,
   input  logic            skip_cond,
   input  logic            next_two_word,
   output logic [PC_W-1:0] nxt,
   output cyc_t            cyc,
   output logic            flush
);
   localparam logic [PC_W-1:0] ONE   = 1;
   localparam logic [PC_W-1:0] TWO   = 2;
   localparam logic [PC_W-1:0] THREE = 3;

   logic [PC_W-1:0] pc_p1;
   assign pc_p1 = pc + ONE;

   always_comb begin
      nxt = pc_p1;
      cyc = CYC_ONE;
      case (cls)
         CLS_RJMP: begin
            nxt = rel_sum;
            cyc = CYC_TWO;
         end
         CLS_IJMP: begin
            nxt = zptr[PC_W-1:0];
            cyc = CYC_TWO;
         end
         CLS_JMP: begin
            nxt = jmp_target;
            cyc = CYC_THREE;
         end
         CLS_BRANCH: begin
            if (flag_hit) begin
               nxt = br_sum;
               cyc = CYC_TWO;
            end
         end
         CLS_SKIP: begin
            if (skip_cond) begin
               nxt = next_two_word ? pc + THREE : pc + TWO;
               cyc = next_two_word ? CYC_THREE : CYC_TWO;
            end
         end
         default: begin
            nxt = pc_p1;
            cyc = CYC_ONE;
         end
      endcase
   end

   assign flush = (nxt != pc_p1);
endmodule

// File: rtl/branch_nextpc_unit.sv
module branch_nextpc_unit
   import bnpc_pkg::*;
#(
   parameter int PC_W   = 16,
   parameter int REL_W  = 12,
   parameter int BR_W   = 7,
   parameter int Z_W    = 16,
   parameter int FLAG_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [2:0]                 cls,
   input  logic [PC_W-1:0]            pc,
   input  logic [REL_W-1:0]           rel_off,
   input  logic [BR_W-1:0]            br_off,
   input  logic [PC_W-1:0]            jmp_target,
   input  logic [Z_W-1:0]             zptr,
   input  logic [FLAG_W-1:0]          sreg,
   input  logic [$clog2(FLAG_W)-1:0]  flag_sel,
   input  logic                       flag_on_set,
   input  logic                       skip_cond,
   input  logic                       next_two_word,
   output logic                       out_valid,
   output logic [PC_W-1:0]            next_pc,
   output logic [1:0]                 cycles,
   output logic                       flush
);
   generate
      if (PC_W < 8 || PC_W > Z_W) begin : g_bad_pc_w
         $fatal(1, "PC_W must lie between 8 and Z_W");
      end
      if (REL_W < 2 || BR_W < 2) begin : g_bad_off_w
         $fatal(1, "offset widths must be at least 2");
      end
      if ((1 << $clog2(FLAG_W)) != FLAG_W || FLAG_W < 2) begin : g_bad_flag_w
         $fatal(1, "FLAG_W must be a power of two");
      end
   endgenerate

   logic [PC_W-1:0] rel_sum;
   logic [PC_W-1:0] br_sum;
   logic [PC_W-1:0] nxt;
   cyc_t            cyc;
   logic            flush_d;
   logic            flag_hit;

   assign flag_hit = (sreg[flag_sel] == flag_on_set);

   bnpc_offset_add #(.PC_W(PC_W), .OFF_W(REL_W)) u_rel_add (
      .base (pc),
      .off  (rel_off),
      .sum  (rel_sum)
   );

   bnpc_offset_add #(.PC_W(PC_W), .OFF_W(BR_W)) u_br_add (
      .base (pc),
      .off  (br_off),
      .sum  (br_sum)
   );

   bnpc_target_sel #(.PC_W(PC_W), .Z_W(Z_W)) u_sel (
      .cls           (cls),
      .pc            (pc),
      .rel_sum       (rel_sum),
      .br_sum        (br_sum),
      .jmp_target    (jmp_target),
      .zptr          (zptr),
      .flag_hit      (flag_hit),
      .skip_cond     (skip_cond),
      .next_two_word (next_two_word),
      .nxt           (nxt),
      .cyc           (cyc),
      .flush         (flush_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         next_pc   <= '0;
         cycles    <= '0;
         flush     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            next_pc <= nxt;
            cycles  <= cyc;
            flush   <= flush_d;
         end
      end
   end
endmodule

// File: rtl/bnpc_checker.sv
module bnpc_checker
   import bnpc_pkg::*;
#(
   parameter int PC_W = 16,
   parameter int Z_W  = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [2:0]      cls,
   input logic [PC_W-1:0] pc,
   input logic [PC_W-1:0] jmp_target,
   input logic [Z_W-1:0]  zptr,
   input logic            skip_cond,
   input logic            next_two_word,
   input logic            out_valid,
   input logic [PC_W-1:0] next_pc,
   input logic [1:0]      cycles,
   input logic            flush
);
   localparam logic [PC_W-1:0] ONE   = 1;
   localparam logic [PC_W-1:0] THREE = 3;

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && next_pc == '0 && cycles == 2'd0 && !flush));

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(next_pc) && $stable(cycles) && $stable(flush)));

   assert_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls == CLS_SEQ) |=> (next_pc == $past(pc) + ONE && cycles == 2'd1 && !flush));

   assert_indirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls == CLS_IJMP) |=> (next_pc == $past(zptr[PC_W-1:0]) && cycles == 2'd2));

   assert_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls == CLS_JMP) |=> (next_pc == $past(jmp_target) && cycles == 2'd3));

   assert_skip_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls == CLS_SKIP && !skip_cond) |=> (next_pc == $past(pc) + ONE && cycles == 2'd1));

   assert_skip_long_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls == CLS_SKIP && skip_cond && next_two_word)
         |=> (next_pc == $past(pc) + THREE && cycles == 2'd3 && flush));

   assert_flush_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (flush == (next_pc != $past(pc) + ONE)));

   assert_spare_class_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls > CLS_SKIP) |=> (next_pc == $past(pc) + ONE && cycles == 2'd1));

   assert_cycles_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> cycles != 2'd0);
endmodule

bind branch_nextpc_unit bnpc_checker #(.PC_W(PC_W), .Z_W(Z_W)) u_chk (.*);

// File: tb/branch_nextpc_unit_tb.sv
`timescale 1ns/1ps
module branch_nextpc_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [2:0]  cls;
   logic [15:0] pc;
   logic [11:0] rel_off;
   logic [6:0]  br_off;
   logic [15:0] jmp_target;
   logic [15:0] zptr;
   logic [7:0]  sreg;
   logic [2:0]  flag_sel;
   logic        flag_on_set;
   logic        skip_cond;
   logic        next_two_word;
   logic        out_valid;
   logic [15:0] next_pc;
   logic [1:0]  cycles;
   logic        flush;

   int total = 0;
   int fails = 0;
   bit done  = 0;

   logic        exp_valid = 0;
   logic [15:0] exp_pc    = 0;
   int          exp_cyc   = 0;
   logic        exp_flush = 0;

   always #2.5 clk = ~clk;

   branch_nextpc_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cls(cls), .pc(pc),
      .rel_off(rel_off), .br_off(br_off), .jmp_target(jmp_target), .zptr(zptr),
      .sreg(sreg), .flag_sel(flag_sel), .flag_on_set(flag_on_set),
      .skip_cond(skip_cond), .next_two_word(next_two_word),
      .out_valid(out_valid), .next_pc(next_pc), .cycles(cycles), .flush(flush)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   // behavioural reference: integer arithmetic, no shared structure with the RTL
   task automatic model(input logic [2:0] c, input logic [15:0] p,
                        input logic [11:0] r, input logic [6:0] b,
                        input logic [15:0] t, input logic [15:0] z,
                        input logic [7:0] s, input logic [2:0] sel, input logic os,
                        input logic sk, input logic tw,
                        output logic [15:0] np, output int cy);
      int base;
      base = int'(p);
      case (c)
         3'd1: begin np = 16'(base + int'($signed(r)) + 1); cy = 2; end
         3'd2: begin np = z; cy = 2; end
         3'd3: begin np = t; cy = 3; end
         3'd4: begin
            if (s[sel] == os) begin np = 16'(base + int'($signed(b)) + 1); cy = 2; end
            else begin np = 16'(base + 1); cy = 1; end
         end
         3'd5: begin
            if (!sk)    begin np = 16'(base + 1); cy = 1; end
            else if (tw) begin np = 16'(base + 3); cy = 3; end
            else         begin np = 16'(base + 2); cy = 2; end
         end
         default: begin np = 16'(base + 1); cy = 1; end
      endcase
   endtask

   task automatic step(input logic v, input logic [2:0] c, input logic [15:0] p,
                       input logic [11:0] r, input logic [6:0] b,
                       input logic [15:0] t, input logic [15:0] z,
                       input logic [7:0] s, input logic [2:0] sel, input logic os,
                       input logic sk, input logic tw, input string tag);
      logic [15:0] np;
      int cy;
      in_valid = v; cls = c; pc = p; rel_off = r; br_off = b; jmp_target = t;
      zptr = z; sreg = s; flag_sel = sel; flag_on_set = os; skip_cond = sk;
      next_two_word = tw;
      exp_valid = v;
      if (v) begin
         model(c, p, r, b, t, z, s, sel, os, sk, tw, np, cy);
         exp_pc    = np;
         exp_cyc   = cy;
         exp_flush = (np != 16'(int'(p) + 1));
      end
      @(negedge clk);
      check(out_valid == exp_valid, "R2", "out_valid", int'(out_valid), int'(exp_valid));
      check(next_pc == exp_pc, tag, "next_pc", int'(next_pc), int'(exp_pc));
      check(int'(cycles) == exp_cyc, tag, "cycles", int'(cycles), exp_cyc);
      check(flush == exp_flush, "R10", "flush", int'(flush), int'(exp_flush));
   endtask

   function automatic string class_tag(input logic [2:0] c);
      case (c)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         3'd5: return "R9";
         default: return "R12";
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: run did not complete");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b1; cls = 3'd3; pc = 16'h1111; rel_off = '0;
      br_off = '0; jmp_target = 16'hABCD; zptr = '0; sreg = '0; flag_sel = '0;
      flag_on_set = 1'b0; skip_cond = 1'b0; next_two_word = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset holds outputs at zero even with a request present
      check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
      check(next_pc == 16'h0, "R1", "next_pc", int'(next_pc), 0);
      check(cycles == 2'd0, "R1", "cycles", int'(cycles), 0);
      check(flush == 1'b0, "R1", "flush", int'(flush), 0);
      rst_n = 1'b1;

      step(1, 3'd0, 16'h1234, 12'h0, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 0, 0, "R3");
      step(1, 3'd6, 16'h0040, 12'h0, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 0, 0, "R12");
      step(1, 3'd7, 16'hFFFF, 12'h0, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 0, 0, "R12");
      // relative jumps: forward, back-to-self, offset zero, wrap, most negative
      step(1, 3'd1, 16'h0100, 12'h005, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 0, 0, "R4");
      step(1, 3'd1, 16'h0100, 12'hFFF, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 0, 0, "R4");
      step(1, 3'd1, 16'h0100, 12'h000, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 0, 0, "R10");
      step(1, 3'd1, 16'hFFFF, 12'h001, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 0, 0, "R11");
      step(1, 3'd1, 16'h0010, 12'h800, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 0, 0, "R11");
      step(1, 3'd1, 16'h1000, 12'h7FF, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 0, 0, "R4");
      step(1, 3'd2, 16'h0200, 12'h0, 7'h0, 16'h0, 16'hBEEF, 8'h0, 3'd0, 0, 0, 0, "R5");
      step(1, 3'd2, 16'h0200, 12'h0, 7'h0, 16'h0, 16'h0201, 8'h0, 3'd0, 0, 0, 0, "R10");
      step(1, 3'd3, 16'h0300, 12'h0, 7'h0, 16'h7A5C, 16'h0, 8'h0, 3'd0, 0, 0, 0, "R6");
      // R2: idle cycles hold the last result
      step(0, 3'd1, 16'h9999, 12'h123, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 0, 0, "R2");
      step(0, 3'd0, 16'h0000, 12'h0, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 0, 0, "R2");
      // branches on zero flag (bit 1)
      step(1, 3'd4, 16'h0400, 12'h0, 7'h3F, 16'h0, 16'h0, 8'h02, 3'd1, 1, 0, 0, "R7");
      step(1, 3'd4, 16'h0400, 12'h0, 7'h40, 16'h0, 16'h0, 8'h02, 3'd1, 1, 0, 0, "R7");
      step(1, 3'd4, 16'h0400, 12'h0, 7'h10, 16'h0, 16'h0, 8'h02, 3'd1, 0, 0, 0, "R7");
      step(1, 3'd4, 16'h0000, 12'h0, 7'h7E, 16'h0, 16'h0, 8'h00, 3'd1, 0, 0, 0, "R11");
      // R8: carry and signed conditions; bit 4 = N^V
      step(1, 3'd4, 16'h0500, 12'h0, 7'h08, 16'h0, 16'h0, 8'h00, 3'd0, 0, 0, 0, "R8");
      step(1, 3'd4, 16'h0500, 12'h0, 7'h08, 16'h0, 16'h0, 8'h01, 3'd0, 0, 0, 0, "R8");
      step(1, 3'd4, 16'h0500, 12'h0, 7'h08, 16'h0, 16'h0, 8'h01, 3'd0, 1, 0, 0, "R8");
      step(1, 3'd4, 16'h0600, 12'h0, 7'h04, 16'h0, 16'h0, 8'h0C, 3'd4, 0, 0, 0, "R8");
      step(1, 3'd4, 16'h0600, 12'h0, 7'h04, 16'h0, 16'h0, 8'h0C, 3'd4, 1, 0, 0, "R8");
      step(1, 3'd4, 16'h0600, 12'h0, 7'h04, 16'h0, 16'h0, 8'h14, 3'd4, 1, 0, 0, "R8");
      step(1, 3'd4, 16'h0600, 12'h0, 7'h04, 16'h0, 16'h0, 8'h18, 3'd4, 0, 0, 0, "R8");
      // skips
      step(1, 3'd5, 16'h0700, 12'h0, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 0, 1, "R9");
      step(1, 3'd5, 16'h0700, 12'h0, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 1, 0, "R9");
      step(1, 3'd5, 16'h0700, 12'h0, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 1, 1, "R9");
      step(1, 3'd5, 16'hFFFE, 12'h0, 7'h0, 16'h0, 16'h0, 8'h0, 3'd0, 0, 1, 1, "R11");

      for (int i = 0; i < 400; i++) begin
         logic [2:0]  c;
         logic [7:0]  s;
         c = 3'($urandom_range(0, 7));
         s = 8'($urandom);
         s[4] = s[2] ^ s[3];
         step(1'($urandom_range(0, 3) != 0), c, 16'($urandom), 12'($urandom),
              7'($urandom), 16'($urandom), 16'($urandom), s, 3'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), class_tag(c));
      end

      done = 1;
      summary();
      $finish;
   end
endmodule